// File: doc/BRIEF.md
# Receive Buffer Congestion Threshold Monitor

This block watches the fill level of a bank of receive packet FIFOs (eight by default) and raises three congestion indications for each of them: a pause request for link-level flow control, a drop request, and an ECN marking request. The levels for each indication come from the FIFO's configured size by a separate rule. Pause keeps a fixed skid reserve below the top and releases at a low-water mark. Drop leaves room for exactly one maximum-length jumbo frame. ECN marks once the larger of a quarter of capacity and one jumbo frame is occupied. The block also reports the credit count that belongs to each FIFO's size.

Size is given in 2 KB units and occupancy in 64-byte units, so capacity in occupancy units is size × 32. All levels and credits are recomputed combinationally from the configuration inputs. Each indication is held by its own two-state machine. In `FLAG_IDLE` the ENTER transition fires when the indication is enabled and occupancy has reached the on level. In `FLAG_ACTIVE` the EXIT transition fires when the indication is disabled, or when occupancy has fallen below both the off level and the on level. The state register updates on each rising clock edge, so every flag follows its inputs with one cycle of latency.

Top module: `rx_cong_monitor`

## Requirements
- R1: `credit_o` for a FIFO equals size × 32 + 4 when that FIFO's size is nonzero and 0 when it is zero; it is combinational, with no clock between size and credit.
- R2: The pause on level is capacity − SKID_UNITS (default 896 units, a 56 KB skid), held at 0 when capacity is smaller than the skid. The pause off level is SKID_UNITS. An enabled pause flag rises at the first clock edge at which occupancy is at or above the on level.
- R3: An asserted flag is held while occupancy stays at or above the lower of its on and off levels. It clears at the first clock edge at which occupancy is below both levels. A flag that is clear stays clear below its on level.
- R4: The drop on level and off level are both capacity − ⌊jumbo length / 64⌋, held at 0 when that value would be negative.
- R5: The ECN on level and off level are both max(capacity / 4, ⌊jumbo length / 64⌋).
- R6: Bit i of `pause_mask_i`, `drop_mask_i` or `ecn_mask_i` enables the matching indication of FIFO i. While that bit is 0 the flag never asserts at any occupancy, and a flag that was asserted clears at the next clock edge.
- R7: A FIFO whose size is 0 raises no indication at any occupancy and with all mask bits set.
- R8: While `pause_en_i` is 0 every pause flag is 0 from the next clock edge on; drop and ECN flags are unaffected. When `pause_en_i` returns to 1, pause follows the rules of R2 again.
- R9: While `rst_n` is low every flag is 0.
- R10: Flags are registered. A change of occupancy is visible on the flags only after the next rising clock edge, never before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pause_en_i | input | 1 | Global enable for all pause flags |
| occ_i | input | N_FIFO*(SIZE_W+5) | Per-FIFO occupancy in 64-byte units, FIFO i in slice i |
| size_i | input | N_FIFO*SIZE_W | Per-FIFO size in 2 KB units, FIFO i in slice i |
| jumbo_len_i | input | JUMBO_W | Maximum jumbo frame length in bytes |
| pause_mask_i | input | N_FIFO | Per-FIFO pause enable |
| drop_mask_i | input | N_FIFO | Per-FIFO drop enable |
| ecn_mask_i | input | N_FIFO | Per-FIFO ECN enable |
| pause_o | output | N_FIFO | Per-FIFO pause request |
| drop_o | output | N_FIFO | Per-FIFO drop request |
| ecn_o | output | N_FIFO | Per-FIFO ECN marking request |
| credit_o | output | N_FIFO*(SIZE_W+6) | Per-FIFO credit count in 64-byte units, FIFO i in slice i |

## Verification
A state machine stuck in `FLAG_ACTIVE` shows up as a flag that stays high after occupancy drops below both levels. A machine stuck in `FLAG_IDLE` shows up as a flag that stays low past its on level. Either fault is visible one clock after the occupancy step that should have moved it. A wrong level computation moves the edge where a flag toggles, so the bench steps occupancy to one unit below each level and then onto it. A lost enable shows as a flag that stays high one cycle after its mask bit, the global pause enable or the FIFO size is removed.

// File: rtl/rx_cong_pkg.sv
package rx_cong_pkg;

    // Hysteresis state of one congestion indication
    typedef enum logic {
        FLAG_IDLE   = 1'b0,
        FLAG_ACTIVE = 1'b1
    } flag_state_e;

    // Indication kinds, used as generate index
    localparam int unsigned KIND_PAUSE = 0;
    localparam int unsigned KIND_DROP  = 1;
    localparam int unsigned KIND_ECN   = 2;
    localparam int unsigned N_KIND     = 3;

endpackage

// File: rtl/rx_cong_thresh.sv
module rx_cong_thresh #(
    parameter int unsigned SIZE_W     = 8,
    parameter int unsigned JUMBO_W    = 14,
    parameter int unsigned SKID_UNITS = 896,
    localparam int unsigned CAP_W     = SIZE_W + 5,
    localparam int unsigned CRED_W    = SIZE_W + 6
) (
    input  logic [SIZE_W-1:0]  size_i,
    input  logic [JUMBO_W-1:0] jumbo_len_i,
    output logic [CAP_W-1:0]   pause_on_o,
    output logic [CAP_W-1:0]   pause_off_o,
    output logic [CAP_W-1:0]   drop_lvl_o,
    output logic [CAP_W-1:0]   ecn_lvl_o,
    output logic [CRED_W-1:0]  credit_o
);

    localparam logic [31:0] CAP_MAX = 32'((64'd1 << CAP_W) - 64'd1);

    // Saturate a wide level into the occupancy width
    function automatic logic [CAP_W-1:0] fit_lvl(input logic [31:0] v);
        return (v > CAP_MAX) ? {CAP_W{1'b1}} : v[CAP_W-1:0];
    endfunction

    logic [31:0] cap_w;
    logic [31:0] jumbo_units;
    logic [31:0] quarter_w;
    logic [31:0] pause_on_w;
    logic [31:0] drop_w;
    logic [31:0] ecn_w;
    logic [31:0] credit_w;

    always_comb begin
        cap_w       = 32'(size_i) << 5;
        jumbo_units = 32'(jumbo_len_i) >> 6;
        quarter_w   = cap_w >> 2;
        pause_on_w  = (cap_w > SKID_UNITS) ? (cap_w - SKID_UNITS) : 32'd0;
        drop_w      = (cap_w > jumbo_units) ? (cap_w - jumbo_units) : 32'd0;
        ecn_w       = (quarter_w > jumbo_units) ? quarter_w : jumbo_units;
        credit_w    = (size_i == '0) ? 32'd0 : (cap_w + 32'd4);
    end

    assign pause_on_o  = fit_lvl(pause_on_w);
    assign pause_off_o = fit_lvl(32'(SKID_UNITS));
    assign drop_lvl_o  = fit_lvl(drop_w);
    assign ecn_lvl_o   = fit_lvl(ecn_w);
    assign credit_o    = credit_w[CRED_W-1:0];

endmodule

// File: rtl/rx_cong_flag.sv
module rx_cong_flag
    import rx_cong_pkg::*;
#(
    parameter int unsigned CAP_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [CAP_W-1:0] occ_i,
    input  logic [CAP_W-1:0] on_lvl_i,
    input  logic [CAP_W-1:0] off_lvl_i,
    output logic             flag_o
);

    flag_state_e state_q;
    flag_state_e state_d;
    logic        enter_c;
    logic        exit_c;

    assign enter_c = enable_i && (occ_i >= on_lvl_i);
    assign exit_c  = !enable_i || ((occ_i < off_lvl_i) && (occ_i < on_lvl_i));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:   if (enter_c) state_d = FLAG_ACTIVE;
            FLAG_ACTIVE: if (exit_c)  state_d = FLAG_IDLE;
            default:     state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            FLAG_ACTIVE: flag_o = 1'b1;
            default:     flag_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/rx_cong_monitor.sv
module rx_cong_monitor
    import rx_cong_pkg::*;
#(
    parameter int unsigned N_FIFO     = 8,
    parameter int unsigned SIZE_W     = 8,
    parameter int unsigned JUMBO_W    = 14,
    parameter int unsigned SKID_UNITS = 896,
    localparam int unsigned CAP_W     = SIZE_W + 5,
    localparam int unsigned CRED_W    = SIZE_W + 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pause_en_i,
    input  logic [N_FIFO*CAP_W-1:0]  occ_i,
    input  logic [N_FIFO*SIZE_W-1:0] size_i,
    input  logic [JUMBO_W-1:0]       jumbo_len_i,
    input  logic [N_FIFO-1:0]        pause_mask_i,
    input  logic [N_FIFO-1:0]        drop_mask_i,
    input  logic [N_FIFO-1:0]        ecn_mask_i,
    output logic [N_FIFO-1:0]        pause_o,
    output logic [N_FIFO-1:0]        drop_o,
    output logic [N_FIFO-1:0]        ecn_o,
    output logic [N_FIFO*CRED_W-1:0] credit_o
);

    for (genvar f = 0; f < N_FIFO; f++) begin : g_fifo
        logic [SIZE_W-1:0] size_f;
        logic [CAP_W-1:0]  occ_f;
        logic [CAP_W-1:0]  pause_on;
        logic [CAP_W-1:0]  pause_off;
        logic [CAP_W-1:0]  drop_lvl;
        logic [CAP_W-1:0]  ecn_lvl;
        logic              live;
        logic [CAP_W-1:0]  on_lv  [N_KIND];
        logic [CAP_W-1:0]  off_lv [N_KIND];
        logic              en     [N_KIND];
        logic              fl     [N_KIND];

        assign size_f = size_i[f*SIZE_W +: SIZE_W];
        assign occ_f  = occ_i[f*CAP_W +: CAP_W];
        assign live   = (size_f != '0);

        rx_cong_thresh #(
            .SIZE_W     (SIZE_W),
            .JUMBO_W    (JUMBO_W),
            .SKID_UNITS (SKID_UNITS)
        ) i_thresh (
            .size_i      (size_f),
            .jumbo_len_i (jumbo_len_i),
            .pause_on_o  (pause_on),
            .pause_off_o (pause_off),
            .drop_lvl_o  (drop_lvl),
            .ecn_lvl_o   (ecn_lvl),
            .credit_o    (credit_o[f*CRED_W +: CRED_W])
        );

        for (genvar k = 0; k < N_KIND; k++) begin : g_kind
            if (k == KIND_PAUSE) begin : g_pause
                assign on_lv[k]  = pause_on;
                assign off_lv[k] = pause_off;
                assign en[k]     = live && pause_mask_i[f] && pause_en_i;
            end else if (k == KIND_DROP) begin : g_drop
                assign on_lv[k]  = drop_lvl;
                assign off_lv[k] = drop_lvl;
                assign en[k]     = live && drop_mask_i[f];
            end else begin : g_ecn
                assign on_lv[k]  = ecn_lvl;
                assign off_lv[k] = ecn_lvl;
                assign en[k]     = live && ecn_mask_i[f];
            end

            rx_cong_flag #(
                .CAP_W (CAP_W)
            ) i_flag (
                .clk       (clk),
                .rst_n     (rst_n),
                .enable_i  (en[k]),
                .occ_i     (occ_f),
                .on_lvl_i  (on_lv[k]),
                .off_lvl_i (off_lv[k]),
                .flag_o    (fl[k])
            );
        end

        assign pause_o[f] = fl[KIND_PAUSE];
        assign drop_o[f]  = fl[KIND_DROP];
        assign ecn_o[f]   = fl[KIND_ECN];
    end

endmodule

// File: rtl/rx_cong_chk.sv
module rx_cong_chk #(
    parameter int unsigned N_FIFO  = 8,
    parameter int unsigned SIZE_W  = 8,
    parameter int unsigned JUMBO_W = 14,
    localparam int unsigned CAP_W  = SIZE_W + 5,
    localparam int unsigned CRED_W = SIZE_W + 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     pause_en_i,
    input logic [N_FIFO*CAP_W-1:0]  occ_i,
    input logic [N_FIFO*SIZE_W-1:0] size_i,
    input logic [JUMBO_W-1:0]       jumbo_len_i,
    input logic [N_FIFO-1:0]        pause_mask_i,
    input logic [N_FIFO-1:0]        drop_mask_i,
    input logic [N_FIFO-1:0]        ecn_mask_i,
    input logic [N_FIFO-1:0]        pause_o,
    input logic [N_FIFO-1:0]        drop_o,
    input logic [N_FIFO-1:0]        ecn_o,
    input logic [N_FIFO*CRED_W-1:0] credit_o
);

    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |-> (pause_o == '0 && drop_o == '0 && ecn_o == '0));

    assert_global_pause_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pause_en_i |=> (pause_o == '0));

    for (genvar g = 0; g < N_FIFO; g++) begin : g_chk
        assert_credit_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (size_i[g*SIZE_W +: SIZE_W] == '0) == (credit_o[g*CRED_W +: CRED_W] == '0));

        assert_empty_fifo_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (size_i[g*SIZE_W +: SIZE_W] == '0) |=> !(pause_o[g] || drop_o[g] || ecn_o[g]));

        assert_pause_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !pause_mask_i[g] |=> !pause_o[g]);

        assert_drop_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !drop_mask_i[g] |=> !drop_o[g]);

        assert_ecn_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !ecn_mask_i[g] |=> !ecn_o[g]);

        assert_ecn_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ecn_o[g]) |-> ($past(occ_i[g*CAP_W +: CAP_W]) >= CAP_W'($past(jumbo_len_i) >> 6)));

        assert_pause_rise_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pause_o[g]) |-> ($past(pause_en_i) && $past(pause_mask_i[g])));
    end

endmodule

bind rx_cong_monitor rx_cong_chk #(
    .N_FIFO  (N_FIFO),
    .SIZE_W  (SIZE_W),
    .JUMBO_W (JUMBO_W)
) i_rx_cong_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pause_en_i   (pause_en_i),
    .occ_i        (occ_i),
    .size_i       (size_i),
    .jumbo_len_i  (jumbo_len_i),
    .pause_mask_i (pause_mask_i),
    .drop_mask_i  (drop_mask_i),
    .ecn_mask_i   (ecn_mask_i),
    .pause_o      (pause_o),
    .drop_o       (drop_o),
    .ecn_o        (ecn_o),
    .credit_o     (credit_o)
);

// File: tb/test_rx_cong_monitor.sv
module test_rx_cong_monitor;

    localparam int unsigned N      = 8;
    localparam int unsigned SW     = 8;
    localparam int unsigned JW     = 14;
    localparam int unsigned CW     = SW + 5;
    localparam int unsigned RW     = SW + 6;
    localparam time         CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pause_en = 1'b1;
    logic [N*CW-1:0]   occ_bus;
    logic [N*SW-1:0]   size_bus;
    logic [JW-1:0]     jumbo = 14'd9728;
    logic [N-1:0]      pmask = 8'h14;
    logic [N-1:0]      dmask = 8'h7d;
    logic [N-1:0]      emask = 8'h10;
    logic [N-1:0]      pause_o;
    logic [N-1:0]      drop_o;
    logic [N-1:0]      ecn_o;
    logic [N*RW-1:0]   credit_o;

    logic [CW-1:0] occ_a  [N];
    logic [SW-1:0] size_a [N];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            occ_bus[i*CW +: CW]  = occ_a[i];
            size_bus[i*SW +: SW] = size_a[i];
        end
    end

    rx_cong_monitor #(
        .N_FIFO (N), .SIZE_W (SW), .JUMBO_W (JW)
    ) i_rx_cong_monitor (
        .clk (clk), .rst_n (rst_n), .pause_en_i (pause_en),
        .occ_i (occ_bus), .size_i (size_bus), .jumbo_len_i (jumbo),
        .pause_mask_i (pmask), .drop_mask_i (dmask), .ecn_mask_i (emask),
        .pause_o (pause_o), .drop_o (drop_o), .ecn_o (ecn_o), .credit_o (credit_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one clock edge, then settle away from it
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] exp_credit(input logic [SW-1:0] s);
        return (s == 0) ? 32'd0 : 32'(s) * 32 + 4;
    endfunction

    task automatic t_reset();
        for (int i = 0; i < N; i++) occ_a[i] = 13'd8000;
        size_a[0] = 8'h20; size_a[1] = 8'h00; size_a[2] = 8'h00; size_a[3] = 8'h10;
        size_a[4] = 8'hc0; size_a[5] = 8'h00; size_a[6] = 8'h10; size_a[7] = 8'h00;
        rst_n = 1'b0;
        tick(); tick();
        chk("R9 pause in reset", 32'(pause_o), 0);
        chk("R9 drop in reset",  32'(drop_o),  0);
        chk("R9 ecn in reset",   32'(ecn_o),   0);
        for (int i = 0; i < N; i++) occ_a[i] = '0;
        rst_n = 1'b1;
        tick();
        chk("R9 flags idle after reset", 32'({pause_o, drop_o, ecn_o}), 0);
    endtask

    task automatic t_credit();
        for (int i = 0; i < N; i++)
            chk("R1 credit", 32'(credit_o[i*RW +: RW]), exp_credit(size_a[i]));
        size_a[5] = 8'hff;
        #1;
        chk("R1 credit max size same cycle", 32'(credit_o[5*RW +: RW]), 32'd8164);
        size_a[5] = 8'h00;
        #1;
        chk("R1 credit zero size", 32'(credit_o[5*RW +: RW]), 0);
    endtask

    task automatic t_pause_hyst();
        // fifo4: capacity 6144, on 5248, off 896
        occ_a[4] = 13'd5247; tick();
        chk("R2 pause below on", 32'(pause_o[4]), 0);
        occ_a[4] = 13'd5248; #1;
        chk("R10 pause before edge", 32'(pause_o[4]), 0);
        tick();
        chk("R2 pause at on level", 32'(pause_o[4]), 1);
        occ_a[4] = 13'd2000; tick();
        chk("R3 pause held mid band", 32'(pause_o[4]), 1);
        occ_a[4] = 13'd896; tick();
        chk("R3 pause held at off", 32'(pause_o[4]), 1);
        occ_a[4] = 13'd895; tick();
        chk("R3 pause clears below off", 32'(pause_o[4]), 0);
        occ_a[4] = 13'd2000; tick();
        chk("R3 pause stays idle mid band", 32'(pause_o[4]), 0);
        occ_a[4] = '0; tick();
    endtask

    task automatic t_drop();
        // fifo0: capacity 1024, level 1024-152=872
        occ_a[0] = 13'd871; tick();
        chk("R4 drop below level", 32'(drop_o[0]), 0);
        occ_a[0] = 13'd872; tick();
        chk("R4 drop at level", 32'(drop_o[0]), 1);
        occ_a[0] = 13'd871; tick();
        chk("R4 drop clears one below", 32'(drop_o[0]), 0);
        // fifo3: capacity 512, level 360
        occ_a[3] = 13'd360; tick();
        chk("R4 drop small fifo", 32'(drop_o[3]), 1);
        occ_a[0] = '0; occ_a[3] = '0; tick();
    endtask

    task automatic t_ecn();
        // fifo4: quarter 1536 dominates jumbo 152
        occ_a[4] = 13'd1535; tick();
        chk("R5 ecn below quarter", 32'(ecn_o[4]), 0);
        occ_a[4] = 13'd1536; tick();
        chk("R5 ecn at quarter", 32'(ecn_o[4]), 1);
        occ_a[4] = 13'd1535; tick();
        chk("R5 ecn clears", 32'(ecn_o[4]), 0);
        // capacity 512: quarter 128 < jumbo 152; pause on clamps to 0
        size_a[4] = 8'h10; occ_a[4] = 13'd151; tick();
        chk("R5 ecn below jumbo floor", 32'(ecn_o[4]), 0);
        chk("R2 pause on level clamped to zero", 32'(pause_o[4]), 1);
        occ_a[4] = 13'd152; tick();
        chk("R5 ecn at jumbo floor", 32'(ecn_o[4]), 1);
        size_a[4] = 8'hc0; occ_a[4] = '0; tick();
        chk("R3 pause clears after resize", 32'(pause_o[4]), 0);
        chk("R5 ecn clears after resize", 32'(ecn_o[4]), 0);
    endtask

    task automatic t_mask();
        size_a[1] = 8'h20; occ_a[1] = 13'd8000; occ_a[4] = 13'd6000; tick();
        chk("R6 drop enabled fifo4", 32'(drop_o[4]), 1);
        chk("R6 drop masked fifo1", 32'(drop_o[1]), 0);
        chk("R6 pause masked fifo1", 32'(pause_o[1]), 0);
        chk("R6 ecn masked fifo1", 32'(ecn_o[1]), 0);
        dmask = 8'h6d; tick();
        chk("R6 drop clears when unmasked", 32'(drop_o[4]), 0);
        dmask = 8'h7d; size_a[1] = '0; occ_a[1] = '0; occ_a[4] = '0; tick();
    endtask

    task automatic t_size_zero();
        pmask = 8'hff; dmask = 8'hff; emask = 8'hff; occ_a[2] = 13'd8191; tick();
        chk("R7 pause zero size", 32'(pause_o[2]), 0);
        chk("R7 drop zero size",  32'(drop_o[2]),  0);
        chk("R7 ecn zero size",   32'(ecn_o[2]),   0);
        pmask = 8'h14; dmask = 8'h7d; emask = 8'h10; occ_a[2] = '0; tick();
    endtask

    task automatic t_pause_global();
        occ_a[4] = 13'd6000; tick();
        chk("R8 pause with global on", 32'(pause_o[4]), 1);
        pause_en = 1'b0; tick();
        chk("R8 pause forced off", 32'(pause_o[4]), 0);
        chk("R8 drop unaffected", 32'(drop_o[4]), 1);
        chk("R8 ecn unaffected", 32'(ecn_o[4]), 1);
        pause_en = 1'b1; tick();
        chk("R8 pause back on", 32'(pause_o[4]), 1);
        occ_a[4] = '0; tick();
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_credit();
        t_pause_hyst();
        t_drop();
        t_ecn();
        t_mask();
        t_size_zero();
        t_pause_global();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule